// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

This block runs on one fast clock and rebuilds two divided clock families, A and C, from counters that share that clock and start together. Each family has its own divide ratio, picked from a small code set, and a range input doubles every ratio when it is low. Whenever the two families rise together, the block tells the system ahead of time with an active-low sync output.

The joint rising edge returns once per frame of fast-clock cycles. The frame is the least common multiple of the two ratios, or twice the ratio when both ratios are equal. Within that frame the sync output drops for one period of the faster family, and it returns high one such period before the next joint edge. Downstream logic can therefore sample the warning on a rising edge of the faster clock and act on the following one.

A reset, or any change to the select inputs, restarts all counters together. The cycle that follows counts as a joint rising edge, and the frame starts over from there.

Top module: `sync_edge_gen`

## Requirements
- R1: While `rst_n` is low, `qa_clk` and `qc_clk` are low and `sync_n` is high.
- R2: Family A divide ratio by code `a_sel` = 0,1,2,3 is 4, 6, 8, 12 fast cycles when `range_hi` is 1, and twice those values when `range_hi` is 0.
- R3: Family C divide ratio by code `c_sel` = 0,1,2,3 is 2, 4, 6, 8 fast cycles when `range_hi` is 1, and twice those values when `range_hi` is 0.
- R4: The first clock edge after reset release is a joint rising edge. Counting that edge's cycle as index 0, each divided clock with ratio N is high at cycle k exactly when k mod N < N/2.
- R5: `sync_n` idles high. Each low pulse lasts exactly P fast cycles, where P is the smaller of the two ratios.
- R6: Each pulse ends (`sync_n` back high) exactly P fast cycles before the next joint rising edge, and that end falls on a rising edge of the faster family.
- R7: For unequal ratios the frame length F is their least common multiple, and exactly one pulse occurs per frame. At cycle index k, with r = F − (k mod F), `sync_n` is low exactly when P < r ≤ 2P.
- R8: When one ratio is an integer multiple of the other, the pulse is still produced by the rule of R7. This includes F = 2P, where the pulse starts on the joint edge itself.
- R9: When both ratios are equal, F is twice the ratio, so the pulse appears on every second output period under the same rule.
- R10: A change of any select input restarts everything on the next clock edge. That edge is a joint rising edge with index 0 under the new ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that drives all counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_hi | input | 1 | 1 selects base ratios, 0 doubles every ratio |
| a_sel | input | 2 | Family A divide ratio code |
| c_sel | input | 2 | Family C divide ratio code |
| qa_clk | output | 1 | Rebuilt family A clock, registered |
| qc_clk | output | 1 | Rebuilt family C clock, registered |
| sync_n | output | 1 | Active-low warning of the next joint rising edge, registered |

## Verification
The hardest case to reach from the ports is a pulse that is cut short or restarted when the select inputs change partway through a frame. Another hard case is a window that opens on the very cycle of a joint edge, which happens when F equals 2P. The bench forces a select change while a long frame is running and then follows the new frame cycle by cycle from index 0. It also runs ratio pairs chosen so that F = 2P, covering both integer multiples and equal ratios. A reference model in the bench finds F by searching for the common multiple. It predicts each output from the distance to the next joint edge rather than from a count window.

// File: rtl/sync_edge_pkg.sv
`timescale 1ns/1ps
package sync_edge_pkg;

  localparam int SEL_W = 2;
  localparam int CFG_W = 2 * SEL_W + 1;
  localparam int N_CFG = 1 << CFG_W;

  typedef struct packed {
    logic             range_hi;
    logic [SEL_W-1:0] a_sel;
    logic [SEL_W-1:0] c_sel;
  } cfg_t;

  // family A: code -> ratio in fast cycles
  function automatic int unsigned a_ratio_of(int unsigned code, int unsigned hi);
    int unsigned base;
    case (code)
      0:       base = 4;
      1:       base = 6;
      2:       base = 8;
      default: base = 12;
    endcase
    return (hi != 0) ? base : 2 * base;
  endfunction

  // family C: code -> ratio in fast cycles
  function automatic int unsigned c_ratio_of(int unsigned code, int unsigned hi);
    int unsigned base;
    base = 2 * (code + 1);
    return (hi != 0) ? base : 2 * base;
  endfunction

  function automatic int unsigned gcd_of(int unsigned x, int unsigned y);
    int unsigned a;
    int unsigned b;
    int unsigned t;
    a = x;
    b = y;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // frame = lcm, doubled when the ratios match so the window fits
  function automatic int unsigned frame_of(int unsigned ra, int unsigned rc);
    int unsigned l;
    l = (ra / gcd_of(ra, rc)) * rc;
    return (ra == rc) ? 2 * l : l;
  endfunction

endpackage

// File: rtl/sync_ratio_decode.sv
`timescale 1ns/1ps
module sync_ratio_decode
  import sync_edge_pkg::*;
#(
  parameter int RATIO_W = 6,
  parameter int FRAME_W = 12
) (
  input  cfg_t               cfg,
  output logic [RATIO_W-1:0] ratio_a,
  output logic [RATIO_W-1:0] ratio_c,
  output logic [RATIO_W-1:0] fast_ratio,
  output logic [FRAME_W-1:0] frame_len,
  output logic               fast_is_a
);

  localparam int SEL_MASK = (1 << SEL_W) - 1;

  logic [RATIO_W-1:0] a_tab [N_CFG];
  logic [RATIO_W-1:0] c_tab [N_CFG];
  logic [FRAME_W-1:0] f_tab [N_CFG];
  logic [CFG_W-1:0]   idx;

  // every configuration is resolved at elaboration; no divider in hardware
  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    localparam int unsigned HI = (g >> (2 * SEL_W)) & 1;
    localparam int unsigned CA = (g >> SEL_W) & SEL_MASK;
    localparam int unsigned CC = g & SEL_MASK;
    localparam int unsigned RA = a_ratio_of(CA, HI);
    localparam int unsigned RC = c_ratio_of(CC, HI);
    localparam int unsigned FL = frame_of(RA, RC);
    assign a_tab[g] = RATIO_W'(RA);
    assign c_tab[g] = RATIO_W'(RC);
    assign f_tab[g] = FRAME_W'(FL);
  end

  assign idx        = cfg;
  assign ratio_a    = a_tab[idx];
  assign ratio_c    = c_tab[idx];
  assign frame_len  = f_tab[idx];
  assign fast_is_a  = (ratio_a <= ratio_c);
  assign fast_ratio = fast_is_a ? ratio_a : ratio_c;

endmodule

// File: rtl/sync_divider.sv
`timescale 1ns/1ps
module sync_divider #(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic [RATIO_W-1:0] cnt,
  output logic               at_zero,
  output logic               clk_out
);

  logic [RATIO_W-1:0] cnt_nxt;
  logic               wrap;

  assign wrap = (cnt == ratio - 1'b1);

  always_comb begin
    if (restart || wrap) cnt_nxt = '0;
    else                 cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      clk_out <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      clk_out <= (cnt_nxt < (ratio >> 1));
    end
  end

  assign at_zero = (cnt == '0);

  // R4: the phase counter never leaves its ratio once running
  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt < ratio));

  // R4: the rebuilt clock only rises at phase zero
  assert_rise_at_phase0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> at_zero);

endmodule

// File: rtl/sync_frame.sv
`timescale 1ns/1ps
module sync_frame #(
  parameter int RATIO_W = 6,
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic [RATIO_W-1:0] fast_ratio,
  output logic [FRAME_W-1:0] fcnt,
  output logic               frame_zero,
  output logic               sync_n
);

  logic [FRAME_W-1:0] fast_w;
  logic [FRAME_W-1:0] win_hi;
  logic [FRAME_W-1:0] win_lo;
  logic [FRAME_W-1:0] fcnt_nxt;
  logic               win_nxt;

  assign fast_w = FRAME_W'(fast_ratio);
  assign win_hi = frame_len - fast_w;
  assign win_lo = win_hi - fast_w;

  always_comb begin
    if (restart || (fcnt == frame_len - 1'b1)) fcnt_nxt = '0;
    else                                       fcnt_nxt = fcnt + 1'b1;
  end

  assign win_nxt = (fcnt_nxt >= win_lo) && (fcnt_nxt < win_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt   <= '0;
      sync_n <= 1'b1;
    end else begin
      fcnt   <= fcnt_nxt;
      sync_n <= !win_nxt;
    end
  end

  assign frame_zero = (fcnt == '0);

  // checker state: length of the current low run, in fast cycles
  logic [RATIO_W:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= '0;
    else if (!win_nxt) low_run <= '0;
    else if (restart)  low_run <= (RATIO_W+1)'(1);
    else               low_run <= low_run + 1'b1;
  end

  // R5: an uninterrupted pulse lasts exactly one fast-family period
  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && !$past(sync_n) && !$past(restart)) |->
      ($past(low_run) == {1'b0, $past(fast_ratio)}));

  // R7: the frame counter stays inside the frame
  assert_frame_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (fcnt < frame_len));

endmodule

// File: rtl/sync_edge_gen.sv
`timescale 1ns/1ps
module sync_edge_gen
  import sync_edge_pkg::*;
#(
  parameter int RATIO_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             range_hi,
  input  logic [SEL_W-1:0] a_sel,
  input  logic [SEL_W-1:0] c_sel,
  output logic             qa_clk,
  output logic             qc_clk,
  output logic             sync_n
);

  localparam int FRAME_W = 2 * RATIO_W;

  cfg_t               cfg_live;
  cfg_t               cfg_q;
  logic               started;
  logic               cfg_chg;
  logic               restart;

  logic [RATIO_W-1:0] ratio_a;
  logic [RATIO_W-1:0] ratio_c;
  logic [RATIO_W-1:0] fast_ratio;
  logic [FRAME_W-1:0] frame_len;
  logic               fast_is_a;

  logic [RATIO_W-1:0] cnt_a;
  logic [RATIO_W-1:0] cnt_c;
  logic               a_zero;
  logic               c_zero;
  logic               fast_zero;
  logic [FRAME_W-1:0] fcnt;
  logic               frame_zero;

  assign cfg_live = '{range_hi: range_hi, a_sel: a_sel, c_sel: c_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      cfg_q   <= '0;
    end else begin
      started <= 1'b1;
      cfg_q   <= cfg_live;
    end
  end

  // named restart event: first edge after reset or any select change
  assign cfg_chg = (cfg_live != cfg_q);
  assign restart = !started || cfg_chg;

  sync_ratio_decode #(.RATIO_W(RATIO_W), .FRAME_W(FRAME_W)) u_dec (
    .cfg        (cfg_live),
    .ratio_a    (ratio_a),
    .ratio_c    (ratio_c),
    .fast_ratio (fast_ratio),
    .frame_len  (frame_len),
    .fast_is_a  (fast_is_a)
  );

  sync_divider #(.RATIO_W(RATIO_W)) u_div_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .ratio   (ratio_a),
    .cnt     (cnt_a),
    .at_zero (a_zero),
    .clk_out (qa_clk)
  );

  sync_divider #(.RATIO_W(RATIO_W)) u_div_c (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .ratio   (ratio_c),
    .cnt     (cnt_c),
    .at_zero (c_zero),
    .clk_out (qc_clk)
  );

  sync_frame #(.RATIO_W(RATIO_W), .FRAME_W(FRAME_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .frame_len  (frame_len),
    .fast_ratio (fast_ratio),
    .fcnt       (fcnt),
    .frame_zero (frame_zero),
    .sync_n     (sync_n)
  );

  assign fast_zero = fast_is_a ? a_zero : c_zero;

  // R7: the frame origin is a phase-zero point of both families
  assert_frame_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_zero |-> (a_zero && c_zero));

  // R6: the pulse ends on a rising edge of the faster family
  assert_end_on_fast_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_n) && !$past(restart) && !restart) |-> fast_zero);

endmodule

// File: tb/sync_edge_gen_bench.sv
`timescale 1ns/1ps
module sync_edge_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       range_hi = 1'b1;
  logic [1:0] a_sel = '0;
  logic [1:0] c_sel = '0;
  logic       qa_clk;
  logic       qc_clk;
  logic       sync_n;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  sync_edge_gen u_sync_edge_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .range_hi (range_hi),
    .a_sel    (a_sel),
    .c_sel    (c_sel),
    .qa_clk   (qa_clk),
    .qc_clk   (qc_clk),
    .sync_n   (sync_n)
  );

  // ratio tables restated from R2 / R3
  function automatic int ref_a(int code, bit hi);
    int t[4] = '{4, 6, 8, 12};
    return hi ? t[code] : 2 * t[code];
  endfunction

  function automatic int ref_c(int code, bit hi);
    int t[4] = '{2, 4, 6, 8};
    return hi ? t[code] : 2 * t[code];
  endfunction

  // frame by search for the first common multiple (R7, R9)
  function automatic int ref_frame(int na, int nc);
    int big = (na > nc) ? na : nc;
    int m = big;
    while ((m % na) != 0 || (m % nc) != 0) m += big;
    return (na == nc) ? 2 * m : m;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // predict outputs at cycle index k from distance to next joint edge
  task automatic check_step(string tag, int k, int na, int nc);
    int f = ref_frame(na, nc);
    int p = (na < nc) ? na : nc;
    int r = f - (k % f);
    logic exp_sync = !((r > p) && (r <= 2 * p));
    check({tag, " R4"}, $sformatf("qa k=%0d", k), qa_clk, logic'((k % na) < na / 2));
    check({tag, " R4"}, $sformatf("qc k=%0d", k), qc_clk, logic'((k % nc) < nc / 2));
    check({tag, " R5 R6"}, $sformatf("sync_n k=%0d", k), sync_n, exp_sync);
  endtask

  task automatic reset_and_check();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "qa in reset", qa_clk, 1'b0);
    check("R1", "qc in reset", qc_clk, 1'b0);
    check("R1", "sync_n in reset", sync_n, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(string tag, bit hi, int a, int c, int ncyc);
    int na = ref_a(a, hi);
    int nc = ref_c(c, hi);
    int f = ref_frame(na, nc);
    int p = (na < nc) ? na : nc;
    int falls = 0;
    int exp_falls = 0;
    logic prev = 1'b1;
    range_hi = hi;
    a_sel = 2'(a);
    c_sel = 2'(c);
    reset_and_check();
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_step(tag, k, na, nc);
      if (prev && !sync_n) falls++;
      prev = sync_n;
    end
    for (int j = 0; j * f + (f - 2 * p) < ncyc; j++) exp_falls++;
    n_vec++;
    if (falls != exp_falls) begin
      n_bad++;
      $display("FAIL R7 pulse count actual=%0d expected=%0d", falls, exp_falls);
    end
  endtask

  // R2 R3 R5 R6 R7: 6 vs 4, frame 12
  task automatic t_unrelated_hi();
    run_cfg("R2 R3 R7", 1'b1, 1, 1, 60);
  endtask

  // R2 R3 R7: doubled range, 24 vs 16, frame 48
  task automatic t_unrelated_lo();
    run_cfg("R2 R3 R7", 1'b0, 3, 3, 150);
  endtask

  // R8: 8 vs 4 (F = 2P) and 12 vs 2
  task automatic t_multiple();
    run_cfg("R8", 1'b1, 2, 1, 40);
    run_cfg("R8", 1'b1, 3, 0, 50);
  endtask

  // R9: equal ratios 4/4 and 8/8
  task automatic t_equal();
    run_cfg("R9", 1'b1, 0, 1, 40);
    run_cfg("R9", 1'b0, 0, 1, 70);
  endtask

  // R10: select change mid-frame restarts at index 0 under new ratios
  task automatic t_change();
    int na;
    int nc;
    run_cfg("R10", 1'b1, 1, 1, 17);
    range_hi = 1'b0;
    a_sel = 2'd2;
    c_sel = 2'd2;
    na = ref_a(2, 1'b0);
    nc = ref_c(2, 1'b0);
    for (int k = 0; k < 110; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_step("R10", k, na, nc);
    end
  endtask

  // R1: asynchronous reset mid-run forces the idle state at once
  task automatic t_reset_mid();
    run_cfg("R1", 1'b1, 1, 1, 9);
    #3 rst_n = 1'b0;
    #1;
    check("R1", "qa after async reset", qa_clk, 1'b0);
    check("R1", "qc after async reset", qc_clk, 1'b0);
    check("R1", "sync_n after async reset", sync_n, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "sync_n held in reset", sync_n, 1'b1);
    rst_n = 1'b1;
  endtask

  initial begin
    t_unrelated_hi();
    t_unrelated_lo();
    t_multiple();
    t_equal();
    t_change();
    t_reset_mid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule